// File: doc/BRIEF.md
# HDLC Transmit Framer with Byte FIFO

This block turns bytes that a host queues into a serial HDLC bit stream, one bit on each clock where the bit enable is high. Each queued byte carries an end-of-message tag. A packet is sent as an opening flag, then the data bytes with zero-bit insertion, then a 16-bit frame check sequence, then a closing flag. When no packet is ready, the line carries continuous fill. The fill is either flag bytes or all-ones idle, picked by a control input. If the queue runs dry before a tagged byte is reached, the packet is abandoned with an abort pattern and a sticky status bit is raised.

The host writes bytes one per clock into a 256-entry queue. The host can watch the queue depth at any time, and a low-water indication compares that depth with one of eight selectable thresholds. A one-clock packet-end pulse marks the end of each closing flag. A second sticky bit records writes that were dropped because the queue was full. Only the synchronous reset clears the sticky bits and empties the queue.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: Reset empties the queue, drives `tx_bit` to 1 and clears all status. After reset, the first eight enabled bits are the abort byte FEh, sent as a 0 followed by seven 1s. Fill follows the abort.
- R2: Fill is sent one byte at a time. With `fill_ones`=0 the fill byte is 7Eh. With `fill_ones`=1 it is FFh. The choice is taken when each fill byte starts.
- R3: At a fill, abort or closing byte boundary, a packet starts only if the queue holds at least two bytes. The packet begins with a 7Eh opening flag, and its data bytes follow.
- R4: Inside data and check bytes, a 0 is inserted after every run of five 1s, including a run that ends the check sequence. Flag, abort and fill bytes are never stuffed.
- R5: After the byte tagged as last, the block sends the check sequence and then a 7Eh closing flag. The check sequence is CRC-16 with reflected polynomial 8408h, preset FFFFh and final complement, and it is sent low bit first. All bytes go out least significant bit first.
- R6: If `crc_off` is 1 when the last data byte completes, no check sequence is sent and the closing flag follows directly.
- R7: After a closing flag, a new packet's opening flag follows at once if two or more bytes are queued. Otherwise fill is sent. Packets are therefore always separated by at least two flags.
- R8: If the queue is empty when a non-last data byte completes, `underrun` sets at that same clock edge. Abort FEh is then sent, followed by fill. `underrun` stays set until reset.
- R9: `fifo_level` gives the number of queued bytes, up to 256. A write to a full queue is dropped and sets the sticky `overflow`.
- R10: `low_water` is high while `fifo_level` is below the threshold picked by `lwm_sel`. Codes 0 to 7 select 4, 16, 32, 48, 64, 96, 128 and 192.
- R11: `pkt_end` pulses for one clock at the edge that sends the last bit of a closing flag. That bit is a 0.
- R12: `tx_bit` changes only at clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance the serial output by one bit |
| wr_en | input | 1 | Queue one byte |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Byte ends a packet |
| fill_ones | input | 1 | Fill select: 1 = FFh idle, 0 = 7Eh flags |
| crc_off | input | 1 | Omit the check sequence |
| lwm_sel | input | 3 | Low-water threshold select |
| tx_bit | output | 1 | Serial HDLC output |
| fifo_level | output | 9 | Queued byte count |
| low_water | output | 1 | Level below selected threshold |
| pkt_end | output | 1 | One-clock pulse at closing flag end |
| underrun | output | 1 | Sticky mid-packet underrun |
| overflow | output | 1 | Sticky dropped write |

## Verification
`tx_bit` is registered. It shows its new value one edge after a clock with `bit_en` high, and it holds otherwise. `fifo_level`, `low_water` and `overflow` reflect a write or a pop at the edge where that write or pop happens. `pkt_end` and `underrun` appear at the edge of the byte-boundary decision that produces them. The bench steps its reference once per clock with the same inputs the design saw at that edge, then compares every output in the following low clock phase. Every result is therefore checked in the first cycle it is due, never later.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } tx_byte_t;

    typedef enum logic [2:0] {
        U_ABORT,
        U_FILL,
        U_OPEN,
        U_DATA,
        U_CRC,
        U_CLOSE
    } unit_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE = 8'hFE;
    localparam logic [7:0]  IDLE_BYTE  = 8'hFF;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam int          STUFF_RUN  = 5;

    // reflected CRC-16 update, data taken least significant bit first
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic int unsigned lwm_threshold(input logic [2:0] sel);
        case (sel)
            3'd0:    return 4;
            3'd1:    return 16;
            3'd2:    return 32;
            3'd3:    return 48;
            3'd4:    return 64;
            3'd5:    return 96;
            3'd6:    return 128;
            default: return 192;
        endcase
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  tx_byte_t      wr_byte,
    input  logic          rd_en,
    output tx_byte_t      rd_byte,
    output logic [LW-1:0] level,
    output logic          overflow
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    tx_byte_t      mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, wr_ok, rd_ok;

    assign full    = (level == LW'(DEPTH));
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && (level != '0);
    assign rd_byte = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_en && full) overflow <= 1'b1;
            if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          fill_ones,
    input  logic          crc_off,
    input  logic [LW-1:0] fifo_level,
    input  tx_byte_t      head,
    output logic          pop,
    output logic          tx_bit,
    output logic          pkt_end,
    output logic          underrun
);
    unit_e       unit, nxt_unit;
    logic [15:0] sh, nxt_sh, crc;
    logic [4:0]  left, nxt_left;
    logic [2:0]  ones;
    logic        cur_last;
    logic        stuff_now, adv, unit_done, stuffable;
    logic        ge2, empty, do_pop, set_udr;

    assign stuff_now = bit_en && (ones == 3'(STUFF_RUN));
    assign adv       = bit_en && !stuff_now;
    assign unit_done = adv && (left == 5'd1);
    assign stuffable = (unit == U_DATA) || (unit == U_CRC);
    assign ge2       = fifo_level >= LW'(2);
    assign empty     = (fifo_level == '0);
    assign pop       = unit_done && do_pop;

    // decision taken at each byte boundary
    always_comb begin
        nxt_unit = unit;
        do_pop   = 1'b0;
        set_udr  = 1'b0;
        case (unit)
            U_OPEN: begin
                nxt_unit = U_DATA;
                do_pop   = 1'b1;
            end
            U_DATA: begin
                if (cur_last)   nxt_unit = crc_off ? U_CLOSE : U_CRC;
                else if (empty) begin
                    nxt_unit = U_ABORT;
                    set_udr  = 1'b1;
                end else begin
                    nxt_unit = U_DATA;
                    do_pop   = 1'b1;
                end
            end
            U_CRC:   nxt_unit = U_CLOSE;
            default: nxt_unit = ge2 ? U_OPEN : U_FILL;
        endcase
        case (nxt_unit)
            U_ABORT: nxt_sh = {8'h00, ABORT_BYTE};
            U_FILL:  nxt_sh = {8'h00, fill_ones ? IDLE_BYTE : FLAG_BYTE};
            U_DATA:  nxt_sh = {8'h00, head.data};
            U_CRC:   nxt_sh = ~crc;
            default: nxt_sh = {8'h00, FLAG_BYTE};
        endcase
        nxt_left = (nxt_unit == U_CRC) ? 5'd16 : 5'd8;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unit     <= U_ABORT;
            sh       <= {8'h00, ABORT_BYTE};
            left     <= 5'd8;
            ones     <= '0;
            crc      <= CRC_PRESET;
            cur_last <= 1'b0;
            tx_bit   <= 1'b1;
            pkt_end  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            pkt_end <= 1'b0;
            if (stuff_now) begin
                tx_bit <= 1'b0;
                ones   <= '0;
            end else if (adv) begin
                tx_bit <= sh[0];
                ones   <= (stuffable && sh[0]) ? ones + 3'd1 : 3'd0;
                if (unit_done) begin
                    unit    <= nxt_unit;
                    sh      <= nxt_sh;
                    left    <= nxt_left;
                    pkt_end <= (unit == U_CLOSE);
                    if (set_udr) underrun <= 1'b1;
                    if (do_pop) begin
                        crc      <= crc16_byte((unit == U_OPEN) ? CRC_PRESET : crc, head.data);
                        cur_last <= head.last;
                    end
                end else begin
                    sh   <= sh >> 1;
                    left <= left - 5'd1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_last,
    input  logic          fill_ones,
    input  logic          crc_off,
    input  logic [2:0]    lwm_sel,
    output logic          tx_bit,
    output logic [LW-1:0] fifo_level,
    output logic          low_water,
    output logic          pkt_end,
    output logic          underrun,
    output logic          overflow
);
    tx_byte_t wr_byte, head;
    logic     pop;

    assign wr_byte = '{last: wr_last, data: wr_data};

    hdlc_tx_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .rd_en    (pop),
        .rd_byte  (head),
        .level    (fifo_level),
        .overflow (overflow)
    );

    hdlc_tx_framer #(.LW(LW)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .fill_ones  (fill_ones),
        .crc_off    (crc_off),
        .fifo_level (fifo_level),
        .head       (head),
        .pop        (pop),
        .tx_bit     (tx_bit),
        .pkt_end    (pkt_end),
        .underrun   (underrun)
    );

    assign low_water = int'(fifo_level) < int'(lwm_threshold(lwm_sel));
endmodule

// File: rtl/hdlc_tx_ctrl_chk.sv
module hdlc_tx_ctrl_chk #(
    parameter int DEPTH = 256,
    parameter int LW    = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_en,
    input logic          wr_en,
    input logic          tx_bit,
    input logic [LW-1:0] fifo_level,
    input logic          pkt_end,
    input logic          underrun,
    input logic          overflow
);
    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level) <= DEPTH);

    p_level_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(fifo_level) <= int'($past(fifo_level)) + 1) &&
                 (int'(fifo_level) + 1 >= int'($past(fifo_level))));

    p_no_grow_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> int'(fifo_level) <= int'($past(fifo_level)));

    p_no_overflow_loss_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    p_pkt_end_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> !pkt_end);

    p_pkt_end_zero_r11: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> !tx_bit);

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));
endmodule

bind hdlc_tx_ctrl hdlc_tx_ctrl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .wr_en      (wr_en),
    .tx_bit     (tx_bit),
    .fifo_level (fifo_level),
    .pkt_end    (pkt_end),
    .underrun   (underrun),
    .overflow   (overflow)
);

// File: tb/test_hdlc_tx_ctrl.sv
`timescale 1ns/100ps
module test_hdlc_tx_ctrl;
    localparam int DEPTH = 256;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, wr_en = 1'b0, wr_last = 1'b0;
    logic fill_ones = 1'b0, crc_off = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] lwm_sel = 3'd0;
    logic tx_bit, low_water, pkt_end, underrun, overflow;
    logic [LW-1:0] fifo_level;

    hdlc_tx_ctrl #(.DEPTH(DEPTH)) i_hdlc_tx_ctrl (
        .clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
        .wr_last(wr_last), .fill_ones(fill_ones), .crc_off(crc_off), .lwm_sel(lwm_sel),
        .tx_bit(tx_bit), .fifo_level(fifo_level), .low_water(low_water),
        .pkt_end(pkt_end), .underrun(underrun), .overflow(overflow)
    );

    always #2 clk = ~clk;

    int compared = 0, mismatched = 0, pe_seen = 0;
    bit finished = 0;
    string phase = "R1";

    // reference model state; unit codes 0 abort,1 fill,2 open,3 data,4 crc,5 close
    int q_data[$], q_last[$], ubits[$];
    int ustate, m_ones, m_crc, m_curlast;
    int m_tx, m_pe, m_udr, m_ovf;

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int thr(int s);
        int t[8] = '{4, 16, 32, 48, 64, 96, 128, 192};
        return t[s];
    endfunction

    function automatic int ref_crc(int c, int d);
        int r = c;
        for (int i = 0; i < 8; i++) begin
            if (((r ^ (d >> i)) & 1) != 0) r = (r >> 1) ^ 'h8408;
            else r = r >> 1;
        end
        return r & 'hFFFF;
    endfunction

    task automatic push_bits(int v, int n);
        for (int i = 0; i < n; i++) ubits.push_back((v >> i) & 1);
    endtask

    task automatic m_load(int st);
        int d;
        ustate = st;
        ubits.delete();
        case (st)
            0: push_bits('hFE, 8);
            1: push_bits(fill_ones ? 'hFF : 'h7E, 8);
            3: begin
                d = q_data.pop_front();
                m_curlast = q_last.pop_front();
                m_crc = ref_crc(m_crc, d);
                push_bits(d, 8);
            end
            4: push_bits((~m_crc) & 'hFFFF, 16);
            default: push_bits('h7E, 8);
        endcase
    endtask

    task automatic m_step();
        int pre, b;
        if (rst) begin
            q_data.delete(); q_last.delete();
            m_ones = 0; m_crc = 'hFFFF; m_curlast = 0;
            m_tx = 1; m_pe = 0; m_udr = 0; m_ovf = 0;
            m_load(0);
            return;
        end
        m_pe = 0;
        pre = q_data.size();
        if (bit_en) begin
            if (m_ones == 5) begin
                m_tx = 0; m_ones = 0;
            end else begin
                b = ubits.pop_front();
                m_tx = b;
                if ((ustate == 3 || ustate == 4) && b == 1) m_ones++;
                else m_ones = 0;
                if (ubits.size() == 0) begin
                    case (ustate)
                        2: begin m_crc = 'hFFFF; m_load(3); end
                        3: begin
                            if (m_curlast != 0) m_load(crc_off ? 5 : 4);
                            else if (q_data.size() == 0) begin m_udr = 1; m_load(0); end
                            else m_load(3);
                        end
                        4: m_load(5);
                        default: begin
                            if (ustate == 5) m_pe = 1;
                            m_load(q_data.size() >= 2 ? 2 : 1);
                        end
                    endcase
                end
            end
        end
        if (wr_en) begin
            if (pre < DEPTH) begin q_data.push_back(wr_data); q_last.push_back(wr_last); end
            else m_ovf = 1;
        end
    endtask

    task automatic compare_all();
        chk(phase, "tx_bit", tx_bit, m_tx);
        chk(phase, "fifo_level", int'(fifo_level), q_data.size());
        chk(phase, "low_water", low_water, q_data.size() < thr(lwm_sel) ? 1 : 0);
        chk(phase, "pkt_end", pkt_end, m_pe);
        chk(phase, "underrun", underrun, m_udr);
        chk(phase, "overflow", overflow, m_ovf);
        if (pkt_end) pe_seen++;
    endtask

    task automatic tick();
        m_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic put(int d, int last);
        wr_en = 1'b1; wr_data = 8'(d); wr_last = last[0];
        tick();
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    initial begin
        int ascii[9] = '{"1", "2", "3", "4", "5", "6", "7", "8", "9"};
        logic [7:0] lfsr = 8'hA7;
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b1;
        run(3);
        chk("R1", "level after reset", int'(fifo_level), 0);
        chk("R1", "tx_bit in reset", tx_bit, 1);
        rst = 1'b0;
        phase = "R1"; run(30);
        phase = "R2"; fill_ones = 1'b1; run(24); fill_ones = 1'b0; run(10);
        phase = "R3"; put('hFF, 0); run(40);
        chk("R3", "single byte waits", int'(fifo_level), 1);
        phase = "R4"; put('hF8, 1); run(60);
        phase = "R5";
        for (int i = 0; i < 9; i++) put(ascii[i], i == 8);
        run(150);
        phase = "R6"; crc_off = 1'b1;
        put('h3E, 0); put('hFF, 0); put('h81, 1);
        run(60); crc_off = 1'b0;
        phase = "R7"; fill_ones = 1'b1; bit_en = 1'b0;
        put('h11, 0); put('h22, 1); put('hFF, 0); put('h7E, 1);
        bit_en = 1'b1; pe_seen = 0; run(200);
        chk("R11", "pkt_end pulses for two packets", pe_seen, 2);
        fill_ones = 1'b0;
        phase = "R12";
        put('hC3, 0); put('h5F, 0); put('hFC, 0); put('h0F, 1);
        for (int i = 0; i < 500; i++) begin
            bit_en = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick();
        end
        bit_en = 1'b1; run(40);
        phase = "R8";
        put('hA5, 0); put('h5A, 0); put('h3C, 0);
        run(80);
        chk("R8", "underrun latched", underrun, 1);
        run(20);
        chk("R8", "underrun still set", underrun, 1);
        phase = "R9"; rst = 1'b1; run(2); rst = 1'b0; bit_en = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            put((i * 37) & 'hFF, (i % 16) == 15);
            if (i + 1 == 3)   begin lwm_sel = 3'd0; #1 chk("R10", "low_water 3<4", low_water, 1); end
            if (i + 1 == 4)   begin lwm_sel = 3'd0; #1 chk("R10", "low_water 4<4", low_water, 0); end
            if (i + 1 == 191) begin lwm_sel = 3'd7; #1 chk("R10", "low_water 191<192", low_water, 1); end
            if (i + 1 == 192) begin lwm_sel = 3'd7; #1 chk("R10", "low_water 192<192", low_water, 0); end
            if (i + 1 == 100) lwm_sel = 3'd5;
        end
        chk("R9", "level at full", int'(fifo_level), DEPTH);
        chk("R9", "overflow set", overflow, 1);
        phase = "R9"; lwm_sel = 3'd4; bit_en = 1'b1;
        run(3200);
        chk("R9", "drained", int'(fifo_level), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog phase=%s actual=timeout expected=completion", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule